// File: doc/BRIEF.md
# Flag Offset Register Programmer

This block holds the four threshold offsets used by the almost-empty and almost-full flag logic of a FIFO pair. FIFO 1 carries data from port A to port B and FIFO 2 carries data from port B to port A. Each FIFO has two offsets. FIFO 1 has `offY1`, the port-A almost-full offset, and `offX1`, the port-B almost-empty offset. FIFO 2 has `offY2`, the port-B almost-full offset, and `offX2`, the port-A almost-empty offset.

When a FIFO reset input goes from low to high, the block samples the two flag-select pins. A non-zero select loads a fixed preset into that FIFO's two offsets. When both resets rise in the same cycle with both select pins low, the block enters programming mode. In that mode the next four port-A writes go to the offset registers instead of FIFO storage. `divert` tells the FIFO to drop those writes.

The reset lines are sampled on `clk`, the port-A clock. A reset line that is asynchronous must be synchronised to `clk` before it reaches the block.

Top module: `flagofs_top`

## Requirements
- R1: While `rst1N` and `rst2N` are both low (master reset), all four offsets, `divert` and `protoErr` are zero one clock later.
- R2: A rising edge of `rst1N` with select `{fs1,fs0}` = 11, 10 or 01 loads 64, 16 or 8 into `offX1` and `offY1` at that clock edge. `offX2` and `offY2` do not change.
- R3: A rising edge of `rst2N` with a non-zero select loads the same preset values into `offX2` and `offY2`. `offX1` and `offY1` do not change.
- R4: When both resets rise in the same cycle with select 00, the block enters programming mode. `divert` is high from the next cycle.
- R5: In programming mode, each clock with `wrEn` high loads `wrData` into one register, in the order `offY1`, `offX1`, `offY2`, `offX2`.
- R6: `divert` falls at the clock edge that takes the fourth load. Later writes do not change any offset.
- R7: A select pin that is high while programming mode is latched sets `protoErr` at that edge. The write in that cycle does not load. `protoErr` stays high, and blocks all further loads, until a master reset.
- R8: A rising edge on only one reset with select 00 leaves all offsets unchanged and does not raise `divert`.
- R9: When no reset edge occurs and `divert` is low, all four offsets keep their values whatever `wrEn` and `wrData` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port-A clock |
| rst1N | input | 1 | FIFO 1 reset, active low, synchronous to `clk` |
| rst2N | input | 1 | FIFO 2 reset, active low, synchronous to `clk` |
| fs0 | input | 1 | Flag-select pin, low bit |
| fs1 | input | 1 | Flag-select pin, high bit |
| wrEn | input | 1 | Port-A write strobe into FIFO 1 |
| wrData | input | OFS_W | Low bits of the port-A data bus |
| divert | output | 1 | High while writes are taken as offset loads |
| protoErr | output | 1 | Sticky select-pin violation in programming mode |
| offX1 | output | OFS_W | Port-B almost-empty offset (FIFO 1) |
| offY1 | output | OFS_W | Port-A almost-full offset (FIFO 1) |
| offX2 | output | OFS_W | Port-A almost-empty offset (FIFO 2) |
| offY2 | output | OFS_W | Port-B almost-full offset (FIFO 2) |

## Verification
The properties assume that the reset lines are already synchronous to `clk` and that a reset edge is a single clean transition. They also assume the select pins are settled in the cycle in which a reset rises. The stimulus changes resets, select pins and write data only on the falling clock edge. It holds each reset low for several cycles before releasing it. It moves the select pins away from 00 during programming mode only in the test that deliberately provokes `protoErr`.

// File: rtl/flagofs_pkg.sv
package flagofs_pkg;

  localparam int NUM_OFS = 4;

  // Register slot indices; the slot order is also the programming order.
  localparam int SLOT_Y1 = 0;
  localparam int SLOT_X1 = 1;
  localparam int SLOT_Y2 = 2;
  localparam int SLOT_X2 = 3;

  typedef struct packed {
    logic                clrAll;   // master reset: clear every slot
    logic                presetA;  // FIFO 1 reset edge with a preset select
    logic                presetB;  // FIFO 2 reset edge with a preset select
    logic [1:0]          sel;      // {fs1,fs0}
    logic [NUM_OFS-1:0]  ldPar;    // one-hot programming load, by slot
  } ofsStrobe_t;

endpackage

// File: rtl/flagofs_ctrl.sv
module flagofs_ctrl
  import flagofs_pkg::*;
(
  input  logic       clk,
  input  logic       rst1N,
  input  logic       rst2N,
  input  logic       fs0,
  input  logic       fs1,
  input  logic       wrEn,
  output ofsStrobe_t strb,
  output logic       divert,
  output logic       protoErr
);

  localparam int LOADS = NUM_OFS;
  localparam int CNT_W = $clog2(LOADS + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(LOADS);

  logic             prev1, prev2;
  logic             parMode;
  logic [CNT_W-1:0] loadCnt;
  logic             rise1, rise2, masterRst, selLow, enterPar, violate, accept;

  always_comb begin
    rise1     = rst1N & ~prev1;
    rise2     = rst2N & ~prev2;
    masterRst = ~rst1N & ~rst2N;
    selLow    = ~fs0 & ~fs1;
    enterPar  = rise1 & rise2 & selLow;
    divert    = parMode & (loadCnt != CNT_DONE);
    violate   = parMode & ~selLow & rst1N;
    accept    = divert & wrEn & ~violate & ~protoErr & rst1N;
  end

  always_comb begin
    strb.clrAll  = masterRst;
    strb.presetA = rise1 & ~selLow;
    strb.presetB = rise2 & ~selLow;
    strb.sel     = {fs1, fs0};
    for (int i = 0; i < NUM_OFS; i++)
      strb.ldPar[i] = accept && (loadCnt == CNT_W'(i));
  end

  always_ff @(posedge clk) begin
    prev1 <= rst1N;
    prev2 <= rst2N;

    if (enterPar)      parMode <= 1'b1;
    else if (!rst1N)   parMode <= 1'b0;

    if (masterRst)     loadCnt <= CNT_DONE;
    else if (enterPar) loadCnt <= '0;
    else if (accept)   loadCnt <= loadCnt + 1'b1;

    if (masterRst)     protoErr <= 1'b0;
    else if (violate)  protoErr <= 1'b1;
  end

endmodule

// File: rtl/flagofs_dp.sv
module flagofs_dp
  import flagofs_pkg::*;
#(
  parameter int OFS_W     = 13,
  parameter int PRESET_HI = 64,
  parameter int PRESET_MD = 16,
  parameter int PRESET_LO = 8
) (
  input  logic                           clk,
  input  ofsStrobe_t                     strb,
  input  logic [OFS_W-1:0]               wrData,
  output logic [NUM_OFS-1:0][OFS_W-1:0]  ofsBus
);

  logic [OFS_W-1:0] presetVal;

  always_comb begin
    unique case (strb.sel)
      2'b11:   presetVal = OFS_W'(PRESET_HI);
      2'b10:   presetVal = OFS_W'(PRESET_MD);
      2'b01:   presetVal = OFS_W'(PRESET_LO);
      default: presetVal = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_OFS; i++) begin : g_slot
    // Slots 0..1 belong to FIFO 1, slots 2..3 to FIFO 2.
    localparam bit IS_FIFO2 = (i >= NUM_OFS / 2);
    logic presetHit;
    logic [OFS_W-1:0] slotQ;

    assign presetHit = IS_FIFO2 ? strb.presetB : strb.presetA;

    always_ff @(posedge clk) begin
      if (strb.clrAll)        slotQ <= '0;
      else if (presetHit)     slotQ <= presetVal;
      else if (strb.ldPar[i]) slotQ <= wrData;
    end

    assign ofsBus[i] = slotQ;
  end

endmodule

// File: rtl/flagofs_top.sv
module flagofs_top
  import flagofs_pkg::*;
#(
  parameter int OFS_W     = 13,
  parameter int PRESET_HI = 64,
  parameter int PRESET_MD = 16,
  parameter int PRESET_LO = 8
) (
  input  logic             clk,
  input  logic             rst1N,
  input  logic             rst2N,
  input  logic             fs0,
  input  logic             fs1,
  input  logic             wrEn,
  input  logic [OFS_W-1:0] wrData,
  output logic             divert,
  output logic             protoErr,
  output logic [OFS_W-1:0] offX1,
  output logic [OFS_W-1:0] offY1,
  output logic [OFS_W-1:0] offX2,
  output logic [OFS_W-1:0] offY2
);

  ofsStrobe_t                    strb;
  logic [NUM_OFS-1:0][OFS_W-1:0] ofsBus;

  flagofs_ctrl ctrl_i (
    .clk(clk), .rst1N(rst1N), .rst2N(rst2N), .fs0(fs0), .fs1(fs1),
    .wrEn(wrEn), .strb(strb), .divert(divert), .protoErr(protoErr)
  );

  flagofs_dp #(
    .OFS_W(OFS_W), .PRESET_HI(PRESET_HI),
    .PRESET_MD(PRESET_MD), .PRESET_LO(PRESET_LO)
  ) dp_i (
    .clk(clk), .strb(strb), .wrData(wrData), .ofsBus(ofsBus)
  );

  assign offY1 = ofsBus[SLOT_Y1];
  assign offX1 = ofsBus[SLOT_X1];
  assign offY2 = ofsBus[SLOT_Y2];
  assign offX2 = ofsBus[SLOT_X2];

endmodule

// File: rtl/flagofs_chk.sv
module flagofs_chk #(
  parameter int OFS_W     = 13,
  parameter int PRESET_HI = 64
) (
  input logic             clk,
  input logic             rst1N,
  input logic             rst2N,
  input logic             fs0,
  input logic             fs1,
  input logic             wrEn,
  input logic             divert,
  input logic             protoErr,
  input logic [OFS_W-1:0] offX1,
  input logic [OFS_W-1:0] offY1,
  input logic [OFS_W-1:0] offX2,
  input logic [OFS_W-1:0] offY2
);

  logic masterRst;
  assign masterRst = !rst1N && !rst2N;

  // R2: top select on a FIFO 1 reset edge yields the high preset.
  p_preset_hi_r2: assert property (@(posedge clk) disable iff (masterRst)
    ($rose(rst1N) && fs1 && fs0) |=> (offX1 == OFS_W'(PRESET_HI) && offY1 == OFS_W'(PRESET_HI)));

  // R8: a lone reset edge with select 00 changes nothing.
  p_lone_zero_r8: assert property (@(posedge clk) disable iff (masterRst)
    ($rose(rst1N) && !$rose(rst2N) && !fs0 && !fs1 && !divert)
      |=> ($stable(offX1) && $stable(offY1) && $stable(offX2) && $stable(offY2) && !divert));

  // R6: outside a reset, divert only ends through an accepted write.
  p_divert_end_r6: assert property (@(posedge clk) disable iff (masterRst)
    ($fell(divert) && rst1N && $past(rst1N)) |-> $past(wrEn));

  // R7: the error flag is sticky until master reset.
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (masterRst)
    protoErr |=> protoErr);

  // R7: with the error flag up, offsets change only on a reset edge.
  p_err_freeze_r7: assert property (@(posedge clk) disable iff (masterRst)
    (protoErr && !$rose(rst1N) && !$rose(rst2N))
      |=> ($stable(offX1) && $stable(offY1) && $stable(offX2) && $stable(offY2)));

  // R9: offsets hold when not diverting and no reset edge occurs.
  p_hold_r9: assert property (@(posedge clk) disable iff (masterRst)
    (!divert && !$rose(rst1N) && !$rose(rst2N))
      |=> ($stable(offX1) && $stable(offY1) && $stable(offX2) && $stable(offY2)));

endmodule

bind flagofs_top flagofs_chk #(.OFS_W(OFS_W), .PRESET_HI(PRESET_HI)) chk_i (.*);

// File: tb/flagofs_top_tb_top.sv
`timescale 1ns/1ps
module flagofs_top_tb_top;

  localparam int OFS_W = 13;

  logic clk = 1'b0;
  logic rst1N = 1'b0, rst2N = 1'b0, fs0 = 1'b0, fs1 = 1'b0, wrEn = 1'b0;
  logic [OFS_W-1:0] wrData = '0;
  logic divert, protoErr;
  logic [OFS_W-1:0] offX1, offY1, offX2, offY2;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  flagofs_top #(.OFS_W(OFS_W)) dut_i (
    .clk(clk), .rst1N(rst1N), .rst2N(rst2N), .fs0(fs0), .fs1(fs1),
    .wrEn(wrEn), .wrData(wrData), .divert(divert), .protoErr(protoErr),
    .offX1(offX1), .offY1(offY1), .offX2(offX2), .offY2(offY2)
  );

  // Vector: {sel[1:0], expected preset[12:0], expected divert}
  localparam int NVEC = 4;
  localparam logic [15:0] VEC [NVEC] = '{
    {2'b11, 13'd64, 1'b0},
    {2'b10, 13'd16, 1'b0},
    {2'b01, 13'd8,  1'b0},
    {2'b00, 13'd0,  1'b1}
  };

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chkAll(string req, int x1, int y1, int x2, int y2);
    chk(req, "offX1", offX1, x1);
    chk(req, "offY1", offY1, y1);
    chk(req, "offX2", offX2, x2);
    chk(req, "offY2", offY2, y2);
  endtask

  task automatic masterReset(logic [1:0] sel);
    rst1N = 1'b0; rst2N = 1'b0; wrEn = 1'b0; {fs1, fs0} = sel;
    tick(4);
    rst1N = 1'b1; rst2N = 1'b1;
    tick();
  endtask

  task automatic wr(int val);
    wrEn = 1'b1; wrData = OFS_W'(val);
    tick();
    wrEn = 1'b0;
  endtask

  initial begin
    tick(3);
    // R1: master reset state
    chkAll("R1", 0, 0, 0, 0);
    chk("R1", "divert", divert, 0);
    chk("R1", "protoErr", protoErr, 0);

    // R2 R3 R4: preset and mode selection table
    for (int v = 0; v < NVEC; v++) begin
      masterReset(VEC[v][15:14]);
      chkAll("R2", VEC[v][13:1], VEC[v][13:1], VEC[v][13:1], VEC[v][13:1]);
      chk("R4", "divert", divert, VEC[v][0]);
    end

    // R5: programming order Y1, X1, Y2, X2, with idle gaps
    wr(100); tick();
    chkAll("R5", 0, 100, 0, 0);
    wr(200); wr(300);
    chk("R5", "divert mid", divert, 1);
    wr(400);
    chkAll("R5", 200, 100, 400, 300);
    // R6: divert drops after the fourth load, later writes ignored
    chk("R6", "divert end", divert, 0);
    wr(999); wr(777);
    chkAll("R6", 200, 100, 400, 300);

    // R7: select pin raised during loading blocks the write and latches error
    masterReset(2'b00);
    wr(55);
    fs1 = 1'b1; wr(77);
    chk("R7", "protoErr", protoErr, 1);
    chkAll("R7", 0, 55, 0, 0);
    fs1 = 1'b0; wr(88); wr(89);
    chk("R7", "protoErr sticky", protoErr, 1);
    chkAll("R7", 0, 55, 0, 0);
    // R1: master reset clears the error
    rst1N = 1'b0; rst2N = 1'b0; tick(2);
    chk("R1", "protoErr cleared", protoErr, 0);
    chkAll("R1", 0, 0, 0, 0);

    // R8: lone FIFO 1 reset edge with select 00
    masterReset(2'b11);
    rst1N = 1'b0; {fs1, fs0} = 2'b00; tick(2);
    rst1N = 1'b1; tick(); tick();
    chkAll("R8", 64, 64, 64, 64);
    chk("R8", "divert", divert, 0);

    // R3: lone FIFO 2 reset edge with select 10
    rst2N = 1'b0; {fs1, fs0} = 2'b10; tick(2);
    rst2N = 1'b1; tick();
    chkAll("R3", 64, 64, 16, 16);

    // R2: lone FIFO 1 reset edge with select 01
    rst1N = 1'b0; {fs1, fs0} = 2'b01; tick(2);
    rst1N = 1'b1; tick();
    chkAll("R2", 8, 8, 16, 16);

    // R9: writes outside programming mode leave offsets alone
    {fs1, fs0} = 2'b00;
    wr(1234); wr(4321); tick(3);
    chkAll("R9", 8, 8, 16, 16);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule